// File: doc/BRIEF.md
# Pipelined Internet Checksum Accumulator

This block keeps a running 16-bit ones-complement sum, of the kind the Internet checksum uses, over data words as they stream past during programmed I/O. Each cycle it may take one 32-bit word. The word is split into two 16-bit halves, and each half goes to its own accumulator lane. Words are never stalled, so a transfer runs at full rate while the checksum is gathered on the side.

Each lane is a 16-bit end-around-carry adder. The adder is cut into short carry-lookahead slices. The carry out of every slice is registered before it reaches the next slice. The carry out of the top slice wraps back into the bottom slice, so the carries form a ring that moves one slice per clock. This keeps the logic depth to a few bits of lookahead. The cost is that, after the last word, the pending carries need a run of idle cycles to drain around the ring.

When the ring has drained, the two lane totals are added in ones-complement into one 16-bit result and held in a register. A ready flag marks the result as valid. A synchronous clear starts a new sum. The result is not complemented. Inserting it into a header is left to the surrounding logic.

Top module: `csum_pipe_acc`

## Requirements
- R1: A word is accepted on every rising edge where `in_valid` is high, with no stall. Bits [15:0] feed lane 0 and bits [31:16] feed lane 1, so both halves count as separate 16-bit checksum words.
- R2: When `sum_ready` is high, `sum_out` is congruent modulo 0xFFFF to the ones-complement (end-around-carry) sum of all 16-bit halves accepted since the last clear or reset. The values 0x0000 and 0xFFFF are treated as equal.
- R3: `sum_ready` is not high before the seventh rising edge that follows the edge accepting the last word: six edges for the carries to settle, plus one for the result register.
- R4: With `in_valid` held low after a word, `sum_ready` rises no later than the 2*SLICES+1-th (13th) rising edge after the last accepted word, and only once no carry is left in either ring.
- R5: Any accepted word drives `sum_ready` low at that same edge.
- R6: A synchronous `clr` makes `sum_ready` 0 and `sum_out` 0x0000 at the next edge, and empties both accumulators and every carry register. After a clear, a sum covers only the words that follow it.
- R7: While `in_valid` stays low and `sum_ready` is high, `sum_out` and `sum_ready` do not change.
- R8: The synchronous active-high `rst` has the same effect as `clr`.
- R9: Streams of all-ones words, and streams that make the top carry wrap on many cycles in a row, still give a result that meets R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear, starts a new sum |
| in_valid | input | 1 | Word strobe |
| in_data | input | 32 | Data word, two 16-bit halves |
| sum_out | output | 16 | Folded ones-complement sum, uncomplemented |
| sum_ready | output | 1 | Result settled and valid |

## Verification
The bench builds the block with its default parameters: two 16-bit lanes, each cut into six slices of widths 3,3,3,3,2,2. The shallow ring lets a short burst of all-ones words leave carries pending in every slice at once. It also lets a lone carry travel a full lap or more before it dies, which tests both the settle count and the upper bound on the ready delay. Random streams of mixed length then check the folded result, while directed streams cover clear in mid-stream and a word arriving while the result is shown.

// File: rtl/csum_pkg.sv
package csum_pkg;

  // Width of slice idx when a w-bit adder is cut into n slices.
  // Any leftover bits go to the lower slices.
  function automatic int slice_w(input int w, input int n, input int idx);
    int base;
    int extra;
    base  = w / n;
    extra = w % n;
    return base + ((idx < extra) ? 1 : 0);
  endfunction

  // Bit position of the lowest bit of slice idx.
  function automatic int slice_lo(input int w, input int n, input int idx);
    int base;
    int extra;
    base  = w / n;
    extra = w % n;
    return idx * base + ((idx < extra) ? idx : extra);
  endfunction

endpackage

// File: rtl/csum_ring_adder.sv
module csum_ring_adder #(
  parameter int W = 16,
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         add_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] acc,
  output logic         busy
);
  import csum_pkg::*;

  logic [W-1:0] acc_q;
  logic [W-1:0] acc_nxt;
  logic [N-1:0] cy_q;    // cy_q[i] is the registered carry into slice i
  logic [N-1:0] cout;    // carry out of each slice, this cycle
  logic [W-1:0] addend;

  assign addend = add_en ? din : '0;

  for (genvar g = 0; g < N; g++) begin : g_slice
    localparam int LO = slice_lo(W, N, g);
    localparam int SW = slice_w(W, N, g);
    logic [SW:0] part;
    always_comb begin
      part = {1'b0, acc_q[LO +: SW]} + {1'b0, addend[LO +: SW]}
           + {{SW{1'b0}}, cy_q[g]};
    end
    assign acc_nxt[LO +: SW] = part[SW-1:0];
    assign cout[g]           = part[SW];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q <= '0;
      cy_q  <= '0;
    end else begin
      acc_q <= acc_nxt;
      // carries move up one slice; the top one wraps to slice 0
      cy_q  <= {cout[N-2:0], cout[N-1]};
    end
  end

  assign acc  = acc_q;
  assign busy = |cy_q;

endmodule

// File: rtl/csum_settle_ctrl.sv
module csum_settle_ctrl #(
  parameter int SETTLE = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic in_valid,
  input  logic carry_busy,
  output logic ready
);
  localparam int CW = $clog2(SETTLE + 1);

  logic [CW-1:0] idle_cnt;
  logic          ready_q;

  always_ff @(posedge clk) begin
    if (rst || clr || in_valid) begin
      idle_cnt <= '0;
    end else if (idle_cnt < CW'(SETTLE)) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr || in_valid) begin
      ready_q <= 1'b0;
    end else begin
      ready_q <= (idle_cnt >= CW'(SETTLE)) && !carry_busy;
    end
  end

  assign ready = ready_q;

endmodule

// File: rtl/csum_fold.sv
module csum_fold #(
  parameter int LANES = 2,
  parameter int W     = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic [LANES*W-1:0]   lane_acc,
  output logic [W-1:0]         sum
);
  logic [W-1:0] folded;
  logic [W-1:0] sum_q;

  always_comb begin
    logic [W:0] wide;
    folded = '0;
    for (int i = 0; i < LANES; i++) begin
      wide   = {1'b0, folded} + {1'b0, lane_acc[i*W +: W]};
      folded = wide[W-1:0] + {{(W-1){1'b0}}, wide[W]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) sum_q <= '0;
    else            sum_q <= folded;
  end

  assign sum = sum_q;

endmodule

// File: rtl/csum_pipe_acc.sv
module csum_pipe_acc #(
  parameter int LANES  = 2,
  parameter int LANE_W = 16,
  parameter int SLICES = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      in_valid,
  input  logic [LANES*LANE_W-1:0]   in_data,
  output logic [LANE_W-1:0]         sum_out,
  output logic                      sum_ready
);
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] lane_acc;
  logic [LANES-1:0]  lane_busy;
  logic              carry_busy;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    csum_ring_adder #(.W(LANE_W), .N(SLICES)) u_ring (
      .clk    (clk),
      .rst    (rst),
      .clr    (clr),
      .add_en (in_valid),
      .din    (in_data[l*LANE_W +: LANE_W]),
      .acc    (lane_acc[l*LANE_W +: LANE_W]),
      .busy   (lane_busy[l])
    );
  end

  assign carry_busy = |lane_busy;

  csum_settle_ctrl #(.SETTLE(SLICES)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .in_valid   (in_valid),
    .carry_busy (carry_busy),
    .ready      (sum_ready)
  );

  csum_fold #(.LANES(LANES), .W(LANE_W)) u_fold (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .lane_acc (lane_acc),
    .sum      (sum_out)
  );

endmodule

// File: rtl/csum_pipe_acc_chk.sv
module csum_pipe_acc_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         clr,
  input logic         in_valid,
  input logic         carry_busy,
  input logic [W-1:0] sum_out,
  input logic         sum_ready
);

  // R5: a word accepted at an edge leaves ready low after that edge
  a_r5_word_drops_ready: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> !sum_ready);

  // R6: clear empties the result and drops ready
  a_r6_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!sum_ready && sum_out == '0));

  // R4: the result is never flagged while a carry is still moving
  a_r4_no_pending_carry: assert property (@(posedge clk) disable iff (rst)
    sum_ready |-> !carry_busy);

  // R7: the shown result holds while the input stays idle
  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (sum_ready && !in_valid && !clr) |=> (sum_ready && $stable(sum_out)));

  // R8: reset leaves ready low and the result zero
  a_r8_reset_state: assert property (@(posedge clk)
    rst |=> (!sum_ready && sum_out == '0));

endmodule

bind csum_pipe_acc csum_pipe_acc_chk #(.W(LANE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clr        (clr),
  .in_valid   (in_valid),
  .carry_busy (carry_busy),
  .sum_out    (sum_out),
  .sum_ready  (sum_ready)
);

// File: tb/csum_pipe_acc_tb.sv
module csum_pipe_acc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SLICES     = 6;
  localparam int MAX_WAIT   = 2 * SLICES + 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic [15:0] sum_out;
  logic        sum_ready;

  int n_checks = 0;
  int n_fail   = 0;
  logic [15:0] ref_sum = '0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csum_pipe_acc #(.LANES(2), .LANE_W(16), .SLICES(SLICES)) u_dut (
    .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid),
    .in_data(in_data), .sum_out(sum_out), .sum_ready(sum_ready)
  );

  function automatic logic [15:0] eac(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] w;
    w = {1'b0, a} + {1'b0, b};
    return w[15:0] + {15'd0, w[16]};
  endfunction

  function automatic logic [15:0] norm(input logic [15:0] v);
    return (v == 16'hFFFF) ? 16'h0000 : v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    ref_sum  = eac(eac(ref_sum, w[15:0]), w[31:16]);
  endtask

  // Go idle, count edges until ready, check latency bounds and the sum.
  task automatic settle_and_check(input string req);
    int n;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = '0;
    n = 0;
    while (n < 3 * MAX_WAIT) begin
      @(posedge clk);
      #1;
      n++;
      if (sum_ready) break;
    end
    // the first idle edge above is the one right after the last word's edge
    check(n >= SLICES + 1, "R3", n, SLICES + 1);
    check(n <= MAX_WAIT, "R4", n, MAX_WAIT);
    check(norm(sum_out) == norm(ref_sum), req, sum_out, ref_sum);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    in_valid = 1'b0;
    @(posedge clk);
    #1;
    check(!sum_ready, "R6", sum_ready, 0);
    check(sum_out == 16'h0, "R6", sum_out, 0);
    @(negedge clk);
    clr = 1'b0;
    ref_sum = '0;
  endtask

  initial begin
    process::self().srandom(32'h1C5A_0071);
    repeat (3) @(posedge clk);
    #1;
    check(!sum_ready, "R8", sum_ready, 0);
    check(sum_out == 16'h0, "R8", sum_out, 0);
    @(negedge clk);
    rst = 1'b0;

    // single word, both halves summed (R1)
    send(32'h1234_5678);
    settle_and_check("R1");

    // hold while idle (R7)
    begin
      logic [15:0] held;
      held = sum_out;
      repeat (5) @(posedge clk);
      #1;
      check(sum_ready && sum_out == held, "R7", sum_out, held);
    end

    // new word while result shown drops ready (R5)
    send(32'h0001_0002);
    @(posedge clk);
    #1;
    check(!sum_ready, "R5", sum_ready, 0);
    settle_and_check("R2");

    // all-ones words (R9)
    do_clear();
    for (int i = 0; i < 20; i++) send(32'hFFFF_FFFF);
    settle_and_check("R9");

    // repeated wrap: near-full pattern then small words
    do_clear();
    for (int i = 0; i < 24; i++) send((i % 2 == 0) ? 32'hFFFF_FFFE : 32'h0001_0003);
    settle_and_check("R9");

    // lone carry round the ring
    do_clear();
    send(32'h0000_FFFF);
    send(32'h0000_0001);
    settle_and_check("R9");

    // clear in mid-stream discards earlier words (R6)
    send(32'hABCD_1234);
    send(32'h5555_AAAA);
    do_clear();
    send(32'h0F0F_F0F0);
    settle_and_check("R6");

    // mid-stream reset behaves like clear (R8)
    send(32'h7777_8888);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(posedge clk);
    #1;
    check(!sum_ready && sum_out == 16'h0, "R8", sum_out, 0);
    @(negedge clk);
    rst = 1'b0;
    ref_sum = '0;
    send(32'h0000_0009);
    settle_and_check("R8");

    // random streams
    for (int s = 0; s < 40; s++) begin
      int len;
      do_clear();
      len = 1 + int'($urandom_range(0, 39));
      for (int i = 0; i < len; i++) begin
        logic [31:0] w;
        case ($urandom_range(0, 3))
          0: w = 32'hFFFF_FFFF;
          1: w = {16'hFFFF, 16'($urandom)};
          default: w = $urandom;
        endcase
        send(w);
      end
      settle_and_check("R2");
    end

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule